// File: doc/BRIEF.md
# Serial Configuration Register Port

This block sits behind a four-wire serial configuration link and gives a host access to a bank of 128 byte-wide registers. A transaction opens when the active-low select drops. The host then clocks in sixteen bits. The first bit is a direction flag. Seven address bits follow, and then eight data bits, each field sent most significant bit first. A write frame stores its data byte in the addressed register. A read frame returns the stored byte on the serial output during the data phase. At every other time the output stays released, which is shown by an output-enable pin.

The port runs in a fast system clock domain. Select, serial clock and serial data are passed through a short synchronizer chain. Edges of the serial clock are found by comparing against the previous synchronized sample. Incoming bits are taken on serial-clock rising edges. Outgoing readback bits change on falling edges, so each bit is steady when the host samples it on the next rise.

Top module: `spiCfgPort`

## Requirements
- R1: A frame is, in time order: one direction bit (1 = read, 0 = write), seven address bits (MSB first) and eight data bits (MSB first). All of them are taken on rising edges of `sck` while `csN` is low.
- R2: In a write frame, the sixteenth rising edge with `csN` still low stores the data byte in the addressed register.
- R3: In a read frame, `sdo` carries the addressed register's stored byte, MSB first. A new bit appears after each falling edge of `sck` in the data phase and holds until the following falling edge.
- R4: `sdoEn` stays 0 for the whole of a write frame, including any bits clocked after the sixteenth.
- R5: In a read frame, `sdoEn` is 0 while the direction and address bits are received. It goes to 1 after the falling edge that follows the eighth rising edge and stays 1 through the eight data bits.
- R6: `csN` going high clears the bit count and drops `sdoEn` to 0 within the synchronizer latency, even in the middle of a read.
- R7: A frame ended by `csN` rising before its sixteenth bit leaves every register unchanged.
- R8: After reset, all 128 registers read as 0x00 and `sdoEn` is 0.
- R9: Bits clocked after the sixteenth, before `csN` rises, are ignored. They cause no second write, either to the addressed register or to the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial link |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial readback data |
| sdoEn | output | 1 | High while `sdo` is driven; low means high impedance |

## Verification
The bench goes after frames that stop early. A design that commits on the last address bit, or on `csN` rising, would corrupt a register on an aborted write. It also sends bits past the sixteenth, which would cause a second write into the same or the next register if the counter wrapped instead of holding. It watches the enable through the address phase of a read: an enable raised one bit early would collide with the host driving the line. Finally it raises select in the middle of a read, where a design that waits for the frame to finish would keep driving a released bus.

// File: rtl/spiCfgPkg.sv
package spiCfgPkg;

  typedef struct packed {
    logic bitVal;     // synchronized serial input bit
    logic shiftIn;    // take bitVal into the input shifter
    logic latchAddr;  // last address bit present: capture address
    logic commit;     // last data bit of a write present
    logic loadOut;    // load readback byte
    logic shiftOut;   // advance readback byte
  } cfgStrobes_t;

endpackage

// File: rtl/spiCfgCtrl.sv
module spiCfgCtrl #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sck,
  input  logic                     sdi,
  output spiCfgPkg::cfgStrobes_t   strobes,
  output logic                     outEn
);
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(1 + ADDR_W);

  logic [SYNC_STAGES-1:0] csPipe, sckPipe, sdiPipe;
  logic                   sckPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic                   rwFlag;
  logic                   csHi, sckNow, sckRise, sckFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      sckPipe <= '0;
      sdiPipe <= '0;
      sckPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      sckPipe <= {sckPipe[SYNC_STAGES-2:0], sck};
      sdiPipe <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      sckPrev <= sckNow;
    end
  end

  assign csHi    = csPipe[SYNC_STAGES-1];
  assign sckNow  = sckPipe[SYNC_STAGES-1];
  assign sckRise = sckNow & ~sckPrev & ~csHi;
  assign sckFall = ~sckNow & sckPrev & ~csHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rwFlag <= 1'b0;
      outEn  <= 1'b0;
    end else if (csHi) begin
      bitCnt <= '0;
      rwFlag <= 1'b0;
      outEn  <= 1'b0;
    end else begin
      if (sckRise && bitCnt != CNT_LAST) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == '0) rwFlag <= sdiPipe[SYNC_STAGES-1];
      end
      if (sckFall) begin
        if (bitCnt == CNT_ADDR && rwFlag) outEn <= 1'b1;
        else if (bitCnt == CNT_LAST)      outEn <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.bitVal    = sdiPipe[SYNC_STAGES-1];
    strobes.shiftIn   = sckRise && bitCnt != CNT_LAST;
    strobes.latchAddr = sckRise && bitCnt == CNT_ADDR - 1'b1;
    strobes.commit    = sckRise && bitCnt == CNT_LAST - 1'b1 && !rwFlag;
    strobes.loadOut   = sckFall && bitCnt == CNT_ADDR && rwFlag;
    strobes.shiftOut  = sckFall && outEn && bitCnt > CNT_ADDR && bitCnt < CNT_LAST;
  end

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> rwFlag);                                               // R4
  AST_OE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEn) |-> bitCnt == CNT_ADDR);                            // R5
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    csHi |=> (!outEn && bitCnt == '0));                              // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_LAST);                                             // R9

endmodule

// File: rtl/spiCfgData.sv
module spiCfgData #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  spiCfgPkg::cfgStrobes_t strobes,
  output logic                   sdoBit
);
  localparam int DEPTH   = 2 ** ADDR_W;
  localparam int SHIFT_W = (ADDR_W > DATA_W ? ADDR_W : DATA_W) - 1;

  logic [SHIFT_W-1:0] inShift;
  logic [ADDR_W-1:0]  addrReg;
  logic [DATA_W-1:0]  outShift;
  logic [DATA_W-1:0]  bank [DEPTH];
  logic [DATA_W-1:0]  commitData;

  assign commitData = {inShift[DATA_W-2:0], strobes.bitVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      addrReg  <= '0;
      outShift <= '0;
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else begin
      if (strobes.shiftIn)
        inShift <= {inShift[SHIFT_W-2:0], strobes.bitVal};
      if (strobes.latchAddr)
        addrReg <= {inShift[ADDR_W-2:0], strobes.bitVal};
      if (strobes.commit)
        bank[addrReg] <= commitData;
      if (strobes.loadOut)
        outShift <= bank[addrReg];
      else if (strobes.shiftOut)
        outShift <= {outShift[DATA_W-2:0], 1'b0};
    end
  end

  assign sdoBit = outShift[DATA_W-1];

  AST_COMMIT_STORES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> bank[$past(addrReg)] == $past(commitData));   // R2
  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadOut || strobes.shiftOut) |=> $stable(sdoBit));     // R3

endmodule

// File: rtl/spiCfgPort.sv
module spiCfgPort #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdoEn
);
  spiCfgPkg::cfgStrobes_t strobes;

  spiCfgCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .strobes(strobes), .outEn(sdoEn)
  );

  spiCfgData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdoBit(sdo)
  );

endmodule

// File: tb/spiCfgPort_tb.sv
module spiCfgPort_tb_top;
  localparam int HALF = 8;
  localparam int NVEC = 10;
  // {rw, addr[6:0], data[7:0], expected readback[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 7'h05, 8'h00, 8'h00},
    {1'b0, 7'h05, 8'hA5, 8'h00},
    {1'b1, 7'h05, 8'h00, 8'hA5},
    {1'b0, 7'h7F, 8'h3C, 8'h00},
    {1'b1, 7'h7F, 8'h00, 8'h3C},
    {1'b0, 7'h00, 8'hFF, 8'h00},
    {1'b1, 7'h00, 8'h00, 8'hFF},
    {1'b0, 7'h05, 8'h5A, 8'h00},
    {1'b1, 7'h05, 8'h00, 8'h5A},
    {1'b1, 7'h7F, 8'h00, 8'h3C}
  };

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdoEn;
  int   nChecks = 0, nFails = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  spiCfgPort dut_i (.clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
                    .sdo(sdo), .sdoEn(sdoEn));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits of word MSB first; collects readback of bits 8..15 and enable views.
  task automatic frame(input logic [23:0] word, input int nbits, input bit closeCs,
                       output logic [7:0] rd, output bit enEarly, output bit enData,
                       output bit enAny);
    rd = '0; enEarly = 0; enData = 1; enAny = 0;
    @(negedge clk); csN = 1'b0;
    for (int b = 0; b < nbits; b++) begin
      sdi = word[23-b];
      waitClk(HALF);
      if (sdoEn) enAny = 1;
      if (b < 8 && sdoEn) enEarly = 1;
      if (b >= 8 && b < 16) begin
        rd = {rd[6:0], sdo};
        if (!sdoEn) enData = 0;
      end
      sck = 1'b1;
      waitClk(HALF);
      if (sdoEn) enAny = 1;
      if (b < 8 && sdoEn) enEarly = 1;
      sck = 1'b0;
    end
    waitClk(HALF);
    if (sdoEn) enAny = 1;
    if (closeCs) begin
      csN = 1'b1;
      waitClk(HALF);
    end
  endtask

  task automatic readReg(input logic [6:0] a, output logic [7:0] rd);
    bit e0, e1, e2;
    frame({1'b1, a, 16'h0}, 16, 1, rd, e0, e1, e2);
  endtask

  initial begin
    logic [7:0] rd;
    bit e0, e1, e2;
    waitClk(3);
    check(sdoEn == 1'b0, "R8 reset enable", int'(sdoEn), 0);
    rstN = 1'b1;
    waitClk(3);
    readReg(7'h2A, rd);
    check(rd == 8'h00, "R8 reset contents", int'(rd), 0);

    for (int v = 0; v < NVEC; v++) begin
      frame({VEC[v][23:8], 8'h00}, 16, 1, rd, e0, e1, e2);
      if (VEC[v][23]) begin
        check(rd == VEC[v][7:0], "R1 R3 readback", int'(rd), int'(VEC[v][7:0]));
        check(!e0 && e1, "R5 read enable window", int'({e0, e1}), 1);
      end else begin
        check(!e2, "R2 R4 write keeps sdo released", int'(e2), 0);
      end
    end

    // R7: aborted write after 12 bits leaves register unchanged
    frame({1'b0, 7'h05, 8'h11, 8'h00}, 12, 1, rd, e0, e1, e2);
    readReg(7'h05, rd);
    check(rd == 8'h5A, "R7 aborted write", int'(rd), 'h5A);
    frame({1'b0, 7'h06, 8'h77, 8'h00}, 15, 1, rd, e0, e1, e2);
    readReg(7'h06, rd);
    check(rd == 8'h00, "R7 abort at 15 bits", int'(rd), 0);

    // R9: extra bits past the sixteenth are ignored
    frame({1'b0, 7'h10, 8'h11, 8'hEE}, 24, 1, rd, e0, e1, e2);
    check(!e2, "R9 R4 enable during long write", int'(e2), 0);
    readReg(7'h10, rd);
    check(rd == 8'h11, "R9 no second write", int'(rd), 'h11);
    readReg(7'h11, rd);
    check(rd == 8'h00, "R9 neighbour untouched", int'(rd), 0);

    // R6: select high in middle of read data phase
    frame({1'b1, 7'h05, 16'h0}, 11, 0, rd, e0, e1, e2);
    check(sdoEn == 1'b1, "R6 enable before release", int'(sdoEn), 1);
    csN = 1'b1;
    waitClk(6);
    check(sdoEn == 1'b0, "R6 release on select high", int'(sdoEn), 0);
    readReg(7'h7F, rd);
    check(rd == 8'h3C, "R6 counter restarts", int'(rd), 'h3C);

    // R8: reset clears written registers
    rstN = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    readReg(7'h05, rd);
    check(rd == 8'h00, "R8 reset clears bank", int'(rd), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule